// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Offset, Binary Scale and Saturation

This block turns the one-bit density stream of a second-order sigma-delta modulator into signed 16-bit words. Every accepted modulator bit (one cycle with `mod_en` high) enters a three-stage integrator chain. At every D-th accepted bit, a three-stage differentiator chain runs at the decimated rate and produces an unsigned raw sum. That sum lies between 0 and D cubed, and half of D cubed means zero input.

An output stage then adds a signed offset and shifts the sum right arithmetically by a programmable amount. It clips the result into the signed 16-bit range, so that a badly chosen scale saturates instead of wrapping and flipping sign. Any clip sets a sticky flag. Software clears the flag by writing a one to `sat_clr`.

Filtering starts only on a `sync` pulse. The pulse also clears all filter state and latches the decimation rate, so that the filter phase can be tied to an external event. The first two words after a start come from a partially filled filter and are marked as not settled.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, `dout`=0, `dout_valid`=0, `dout_early`=0 and `sat_flag`=0. No word is produced until the first `sync` pulse, whatever `mod_en` and `bit_in` do.
- R2: A clock edge with `sync` high clears the integrators, the differentiators, the sample count, the settle count and the output valid. At that edge, `dec_rate` is latched as D, limited to the range 2..DMAX. Samples are taken from the next edge on.
- R3: Each accepted bit counts as +1 (one) or 0 (zero). For an all-ones stream from a start, the first raw word is D(D+1)(D+2)/6. From the third word on, the raw word is D^3 for all ones, 0 for all zeros, and D^3/2 for strictly alternating bits with D even.
- R4: A bit is accepted only on an edge where the filter is started and `mod_en`=1. `dout_valid` is a one-cycle pulse driven at the second edge after the edge that accepts every D-th bit.
- R5: `dout` equals the raw word plus the signed `bias`, shifted right arithmetically by `shift` bits (rounding toward minus infinity), then clipped.
- R6: The clip limits are +32767 and -32768. A value beyond a limit yields that limit.
- R7: `sat_flag` rises one cycle after a clipped word and stays high until an edge with `sat_clr`=1 and no new clip. A new clip wins over a clear.
- R8: `dout_early`=1 with the first and second words after a `sync` and 0 on all later words. It is never high without `dout_valid`.
- R9: `dout_valid` is never high on two consecutive cycles, nor in the cycle after a `sync` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Start/restart pulse; clears state and latches D |
| mod_en | input | 1 | Modulator bit strobe |
| bit_in | input | 1 | Modulator bit |
| dec_rate | input | 9 | Decimation rate D (2..DMAX) |
| bias | input | 26 | Signed offset added to the raw word |
| shift | input | 5 | Arithmetic right shift amount |
| sat_clr | input | 1 | Write-one-to-clear of `sat_flag` |
| dout | output | 16 | Signed output word |
| dout_valid | output | 1 | One-cycle strobe for `dout` |
| dout_early | output | 1 | Word is one of the first two after a start |
| sat_flag | output | 1 | Sticky clip flag |

## Verification
The bench drives each bit at a falling edge and counts falling edges from the one on which `sync` drops. The first word is due on falling edge D+1 when every cycle carries a bit, and on falling edge 2D when only every other cycle does. The bench records the falling edge on which it first sees `dout_valid` and compares that count with the expected one. It compares filtered values only on the third word or later, except for the first all-ones word, whose value is fixed by the cleared start state. `sat_flag` is sampled one falling edge after the word that clipped and one falling edge after a clear pulse.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int ORDER = 3;
    localparam int OUT_W = 16;

    // Accumulator width that keeps modulo arithmetic exact up to DMAX.
    function automatic int acc_bits(input int dmax);
        return 1 + ORDER * $clog2(dmax);
    endfunction

    typedef struct packed {
        logic                    clipped;
        logic signed [OUT_W-1:0] val;
    } clip_t;

    function automatic clip_t clip16(input logic signed [63:0] v);
        clip_t r;
        if (v > 64'sd32767) begin
            r.val     = 16'sh7fff;
            r.clipped = 1'b1;
        end else if (v < -64'sd32768) begin
            r.val     = 16'sh8000;
            r.clipped = 1'b1;
        end else begin
            r.val     = v[OUT_W-1:0];
            r.clipped = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sinc3_pkg::*;
#(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         smp,
    input  logic         bit_in,
    output logic [W-1:0] i3_next
);
    logic [W-1:0] acc_q [ORDER];
    logic [W-1:0] acc_d [ORDER];

    // Chained so that the last stage holds the exact triple running sum.
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign acc_d[k] = acc_q[k] + W'(bit_in);
        end else begin : g_next
            assign acc_d[k] = acc_q[k] + acc_d[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clr)
                acc_q[k] <= '0;
            else if (smp)
                acc_q[k] <= acc_d[k];
        end
    end

    assign i3_next = acc_d[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int W    = 25,
    parameter int DR_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            smp,
    input  logic [DR_W-1:0] dec_q,
    input  logic [W-1:0]    i3_next,
    output logic [W-1:0]    raw_q,
    output logic            raw_vld,
    output logic            raw_early
);
    logic [DR_W-1:0] cnt;
    logic [1:0]      settle;
    logic [W-1:0]    dly   [ORDER];
    logic [W-1:0]    stg_in[ORDER];
    logic [W-1:0]    diff  [ORDER];
    logic            dec_pt;

    assign dec_pt = smp && (cnt == dec_q - 1'b1);

    for (genvar k = 0; k < ORDER; k++) begin : g_diff
        if (k == 0) begin : g_first
            assign stg_in[k] = i3_next;
        end else begin : g_next
            assign stg_in[k] = diff[k-1];
        end
        assign diff[k] = stg_in[k] - dly[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt       <= '0;
            settle    <= '0;
            raw_q     <= '0;
            raw_vld   <= 1'b0;
            raw_early <= 1'b0;
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
        end else begin
            raw_vld <= 1'b0;
            if (smp)
                cnt <= dec_pt ? '0 : cnt + 1'b1;
            if (dec_pt) begin
                for (int k = 0; k < ORDER; k++) dly[k] <= stg_in[k];
                raw_q     <= diff[ORDER-1];
                raw_vld   <= 1'b1;
                raw_early <= (settle != 2'd2);
                if (settle != 2'd2)
                    settle <= settle + 2'd1;
            end
        end
    end

endmodule

// File: rtl/sinc3_post.sv
module sinc3_post
    import sinc3_pkg::*;
#(
    parameter int W    = 25,
    parameter int SH_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [W-1:0]            raw,
    input  logic                    vld,
    input  logic                    early,
    input  logic signed [W:0]       bias,
    input  logic [SH_W-1:0]         shift,
    input  logic                    sat_clr,
    output logic signed [OUT_W-1:0] dout,
    output logic                    dout_valid,
    output logic                    dout_early,
    output logic                    sat_flag,
    output logic                    sat_hit
);
    logic signed [W+1:0] sum;
    logic signed [W+1:0] scaled;
    logic signed [63:0]  wide;
    clip_t               res;

    always_comb begin
        sum     = $signed({2'b00, raw}) + $signed({bias[W], bias});
        scaled  = sum >>> shift;
        wide    = {{(64-W-2){scaled[W+1]}}, scaled};
        res     = clip16(wide);
        sat_hit = vld && !clr && res.clipped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            dout_valid <= 1'b0;
            dout_early <= 1'b0;
            sat_flag   <= 1'b0;
        end else begin
            dout_valid <= vld && !clr;
            dout_early <= vld && !clr && early;
            if (vld && !clr)
                dout <= res.val;
            if (sat_hit)
                sat_flag <= 1'b1;
            else if (sat_clr)
                sat_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int DMAX = 256,
    localparam int W    = acc_bits(DMAX),
    localparam int DR_W = $clog2(DMAX + 1),
    localparam int SH_W = $clog2(W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync,
    input  logic                    mod_en,
    input  logic                    bit_in,
    input  logic [DR_W-1:0]         dec_rate,
    input  logic signed [W:0]       bias,
    input  logic [SH_W-1:0]         shift,
    input  logic                    sat_clr,
    output logic signed [OUT_W-1:0] dout,
    output logic                    dout_valid,
    output logic                    dout_early,
    output logic                    sat_flag
);
    logic            running;
    logic [DR_W-1:0] dec_q;
    logic            smp;
    logic [W-1:0]    i3_next;
    logic [W-1:0]    raw_q;
    logic            raw_vld;
    logic            raw_early;
    logic            sat_hit;

    assign smp = running && mod_en && !sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            dec_q   <= DR_W'(2);
        end else if (sync) begin
            running <= 1'b1;
            if (dec_rate < DR_W'(2))
                dec_q <= DR_W'(2);
            else if (dec_rate > DR_W'(DMAX))
                dec_q <= DR_W'(DMAX);
            else
                dec_q <= dec_rate;
        end
    end

    sinc3_integ #(.W(W)) u_integ (
        .clk(clk), .rst(rst), .clr(sync), .smp(smp),
        .bit_in(bit_in), .i3_next(i3_next)
    );

    sinc3_comb #(.W(W), .DR_W(DR_W)) u_comb (
        .clk(clk), .rst(rst), .clr(sync), .smp(smp), .dec_q(dec_q),
        .i3_next(i3_next), .raw_q(raw_q), .raw_vld(raw_vld),
        .raw_early(raw_early)
    );

    sinc3_post #(.W(W), .SH_W(SH_W)) u_post (
        .clk(clk), .rst(rst), .clr(sync), .raw(raw_q), .vld(raw_vld),
        .early(raw_early), .bias(bias), .shift(shift), .sat_clr(sat_clr),
        .dout(dout), .dout_valid(dout_valid), .dout_early(dout_early),
        .sat_flag(sat_flag), .sat_hit(sat_hit)
    );

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk (
    input logic clk,
    input logic rst,
    input logic sync,
    input logic sat_clr,
    input logic dout_valid,
    input logic dout_early,
    input logic sat_flag,
    input logic sat_hit
);
    // R9
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> !dout_valid);

    // R9
    sync_flush_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> !dout_valid);

    // R7
    sat_set_chk: assert property (@(posedge clk) disable iff (rst)
        sat_hit |=> sat_flag);

    // R7
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag);

    // R7
    sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !sat_hit) |=> !sat_flag);

    // R8
    early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dout_early |-> dout_valid);

endmodule

bind sinc3_decim sinc3_decim_chk u_chk (
    .clk(clk), .rst(rst), .sync(sync), .sat_clr(sat_clr),
    .dout_valid(dout_valid), .dout_early(dout_early),
    .sat_flag(sat_flag), .sat_hit(sat_hit)
);

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

    logic               clk = 1'b0;
    logic               rst;
    logic               sync;
    logic               mod_en;
    logic               bit_in;
    logic [8:0]         dec_rate;
    logic signed [25:0] bias;
    logic [4:0]         shift;
    logic               sat_clr;
    logic signed [15:0] dout;
    logic               dout_valid;
    logic               dout_early;
    logic               sat_flag;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int          got  [4];
    bit          egot [4];
    int          nget;
    int          first_k;
    bit          cons;

    always #4 clk = ~clk;

    sinc3_decim u0 (
        .clk(clk), .rst(rst), .sync(sync), .mod_en(mod_en), .bit_in(bit_in),
        .dec_rate(dec_rate), .bias(bias), .shift(shift), .sat_clr(sat_clr),
        .dout(dout), .dout_valid(dout_valid), .dout_early(dout_early),
        .sat_flag(sat_flag)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pat: 0 zeros, 1 ones, 2 alternating (starts with 1); gap: bit every other cycle
    task automatic run(input int d, input longint bv, input int sh,
                       input int pat, input bit gap, input int nout);
        int s = 0;
        int k = 0;
        bit prev = 0;
        bit en;
        @(negedge clk);
        dec_rate = 9'(d); bias = 26'(bv); shift = 5'(sh);
        mod_en = 0; sync = 1;
        @(negedge clk);
        sync = 0; nget = 0; first_k = 0; cons = 0;
        en = 1;
        mod_en = en; bit_in = (pat == 1) || (pat == 2 && s % 2 == 0);
        if (en) s++;
        while (nget < nout && k < nout * d * 2 + 40) begin
            @(negedge clk);
            k++;
            if (dout_valid) begin
                if (prev) cons = 1;
                if (nget == 0) first_k = k;
                got[nget] = dout; egot[nget] = dout_early;
                nget++;
                prev = 1;
            end else prev = 0;
            en = gap ? ((k + 1) % 2 == 1) : 1'b1;
            mod_en = en;
            bit_in = (pat == 1) || (pat == 2 && s % 2 == 0);
            if (en) s++;
        end
        mod_en = 0;
        chk("R4 word count", nget, nout);
    endtask

    task automatic t_reset;
        chk("R1 dout after reset", dout, 0);
        chk("R1 valid after reset", dout_valid, 0);
        chk("R1 early after reset", dout_early, 0);
        chk("R1 sat_flag after reset", sat_flag, 0);
    endtask

    task automatic t_presync;
        int seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (dout_valid) seen++;
            mod_en = 1; bit_in = i[0];
        end
        mod_en = 0;
        chk("R1 no word before sync", seen, 0);
    endtask

    task automatic t_ones_d8;
        run(8, -256, 0, 1, 0, 3);
        chk("R4 first word latency D+1", first_k, 9);
        chk("R3 first ones word", got[0], 120 - 256);
        chk("R3 R5 settled ones", got[2], 256);
        chk("R8 early word 1", egot[0], 1);
        chk("R8 early word 2", egot[1], 1);
        chk("R8 word 3 settled", egot[2], 0);
        chk("R9 no back-to-back valid", cons, 0);
    endtask

    task automatic t_patterns_d8;
        run(8, -256, 0, 0, 0, 3);
        chk("R3 settled zeros", got[2], -256);
        run(8, -256, 0, 2, 0, 3);
        chk("R3 settled alternating", got[2], 0);
        run(8, -256, 1, 1, 0, 3);
        chk("R5 shift by one", got[2], 128);
        run(8, -255, 2, 0, 0, 3);
        chk("R5 arithmetic shift floors", got[2], -64);
        chk("R7 no clip keeps flag low", sat_flag, 0);
    endtask

    task automatic t_gap;
        run(8, -256, 0, 1, 1, 3);
        chk("R4 gapped latency 2D", first_k, 16);
        chk("R2 R3 restart first word", got[0], 120 - 256);
        chk("R4 gapped settled", got[2], 256);
    endtask

    task automatic t_sat;
        run(64, -131072, 0, 1, 0, 3);
        chk("R6 clip high", got[2], 32767);
        @(negedge clk);
        chk("R7 flag set on clip", sat_flag, 1);
        run(64, -131072, 0, 0, 0, 3);
        chk("R6 clip low", got[2], -32768);
        run(64, -131072, 3, 1, 0, 3);
        chk("R5 no clip after shift", got[2], 16384);
        chk("R7 flag sticky", sat_flag, 1);
        @(negedge clk); sat_clr = 1;
        @(negedge clk); sat_clr = 0;
        chk("R7 flag cleared", sat_flag, 0);
    endtask

    task automatic t_large;
        run(125, -976562, 5, 1, 0, 3);
        chk("R3 R5 D=125 ones", got[2], 30517);
        run(256, -8388608, 9, 1, 0, 3);
        chk("R3 D=256 ones", got[2], 16384);
        run(256, -8388608, 9, 0, 0, 3);
        chk("R3 D=256 zeros", got[2], -16384);
        run(256, -8388608, 8, 1, 0, 3);
        chk("R6 D=256 one past limit", got[2], 32767);
        @(negedge clk);
        chk("R7 flag after edge clip", sat_flag, 1);
    endtask

    task automatic t_clamp;
        run(1, -4, 0, 1, 0, 3);
        chk("R2 rate below 2 becomes 2", got[2], 4);
        chk("R2 clamped latency", first_k, 3);
    endtask

    initial begin
        rst = 1; sync = 0; mod_en = 0; bit_in = 0;
        dec_rate = 9'd8; bias = '0; shift = '0; sat_clr = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_presync;
        t_ones_d8;
        t_patterns_d8;
        t_gap;
        t_sat;
        t_large;
        t_clamp;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule